// File: doc/BRIEF.md
# Diagnostic Flag Output Multiplexer

This block drives one active-low diagnostic output pin that shows one of several internal status flags, chosen by the operating mode and by how many transmit-data pulses have been seen since Normal mode was last entered. It holds three flags itself: wake-up source, bus failure and local failure. Each flag is set by a single-cycle request from the detector that owns it and cleared by its own mode-dependent rule. The power-on flag is kept by the supply monitor and comes in as a level.

In Normal mode a host reads the wake-up-source flag first. It then sends four transmit pulses, each with a long enough dominant phase, after which the pin shows the bus-failure flag. Moving from Normal into Listen-only shows the local-failure flag. Listen-only entered from any other mode shows the power-on flag. In Standby and Sleep the pin is held high. After every mode change the pin keeps its old level for a settling window, and only then shows the newly selected flag. Analog comparators, bus drivers and fault sensing sit outside this block.

Top module: `diag_flag_mux`

## Requirements
- R1: After reset, with mode Standby (mode code 2), errN is high.
- R2: errN is active low: low means the selected flag is set. In Normal mode (code 0), before the fourth qualified TXD edge, errN shows the wake-up-source flag.
- R3: In Normal mode, once four qualified TXD dominant-to-recessive edges (TXD 0 then 1) have occurred, errN shows the bus-failure flag. The edge count saturates at four.
- R4: A TXD edge qualifies only if TXD was sampled low on at least MIN_DOM_CYC consecutive clock cycles just before it. A shorter low phase is ignored.
- R5: The edge count returns to zero on every entry into Normal mode.
- R6: In Listen-only mode (code 1) entered directly from Normal, errN shows the local-failure flag. Listen-only entered from any other mode shows the pwonFlag input.
- R7: In Standby (code 2) and Sleep (code 3), errN is high whatever the flags hold.
- R8: The wake-up-source flag is cleared when Normal mode is left.
- R9: The bus-failure flag is cleared on entry into Normal mode and on a rising edge of pwonFlag.
- R10: The local-failure flag is cleared on entry into Normal mode, on a rising edge of pwonFlag, and on any cycle where RXD is low (dominant), TXD is high (recessive) and localFailActive is low.
- R11: After the cycle in which a mode change is sampled, errN keeps its previous level for SETTLE_CYC further cycles. It shows the new selection from the next cycle on.
- R12: A one-cycle set request latches its flag. Where a set request and a clear fall in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Operating mode: 0 Normal, 1 Listen-only, 2 Standby, 3 Sleep |
| txd | input | 1 | Transmit data, 0 = dominant |
| rxd | input | 1 | Receive data, 0 = dominant |
| setWakeSrc | input | 1 | Set request for the wake-up-source flag |
| setBusFail | input | 1 | Set request for the bus-failure flag |
| setLocalFail | input | 1 | Set request for the local-failure flag |
| localFailActive | input | 1 | A local failure is still present; blocks the RXD/TXD clear |
| pwonFlag | input | 1 | Power-on flag level from the supply monitor |
| errN | output | 1 | Active-low diagnostic output |

## Verification
The bench sweeps the length of the first dominant pulse across the qualification threshold and then adds three pulses that do qualify. A design with an off-by-one threshold would switch to the bus-failure flag one pulse length too early or too late. Every sweep step re-enters Normal mode, so a counter that is not cleared on entry would change flags early. The bench watches the pin through the whole settling window after a change from Sleep to Normal, which catches a design that updates early or late. It also checks each clear rule through the pin, including the RXD/TXD clear being blocked while localFailActive is high, and the pin staying high in Standby and Sleep while flags are set.

// File: rtl/diag_flag_pkg.sv
package diag_flag_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_LISTEN  = 2'd1,
    MODE_STANDBY = 2'd2,
    MODE_SLEEP   = 2'd3
  } opMode_t;

  typedef enum logic [2:0] {
    SHOW_WAKE  = 3'd0,
    SHOW_BUS   = 3'd1,
    SHOW_LOCAL = 3'd2,
    SHOW_PWON  = 3'd3,
    SHOW_HIGH  = 3'd4
  } showSel_t;

  typedef struct packed {
    logic     clrWake;
    logic     clrBus;
    logic     clrLocal;
    logic     updateOut;
    showSel_t sel;
  } ctlStrobes_t;

endpackage

// File: rtl/diag_flag_ctrl.sv
module diag_flag_ctrl
  import diag_flag_pkg::*;
#(
  parameter int MIN_DOM_CYC = 800,
  parameter int SETTLE_CYC  = 1600,
  parameter int EDGE_LIMIT  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  mode,
  input  logic        txd,
  input  logic        rxd,
  input  logic        localFailActive,
  input  logic        pwonFlag,
  output ctlStrobes_t ctl
);

  localparam int DOM_W  = $clog2(MIN_DOM_CYC + 1);
  localparam int SET_W  = $clog2(SETTLE_CYC + 1);
  localparam int EDGE_W = $clog2(EDGE_LIMIT + 1);
  localparam logic [DOM_W-1:0]  DOM_MAX  = DOM_W'(MIN_DOM_CYC);
  localparam logic [SET_W-1:0]  SET_LOAD = SET_W'(SETTLE_CYC);
  localparam logic [EDGE_W-1:0] EDGE_MAX = EDGE_W'(EDGE_LIMIT);

  opMode_t curMode;
  opMode_t modePrev;
  logic listenFromNormal;
  logic txdPrev;
  logic pwonPrev;
  logic [DOM_W-1:0]  domCnt;
  logic [SET_W-1:0]  settleCnt;
  logic [EDGE_W-1:0] edgeCnt;

  logic modeChange, enterNormal, leaveNormal, qualEdge, pwonRise;

  always_comb begin
    curMode     = opMode_t'(mode);
    modeChange  = (curMode != modePrev);
    enterNormal = (curMode == MODE_NORMAL) && (modePrev != MODE_NORMAL);
    leaveNormal = (curMode != MODE_NORMAL) && (modePrev == MODE_NORMAL);
    pwonRise    = pwonFlag && !pwonPrev;
    qualEdge    = !txdPrev && txd && (domCnt >= DOM_MAX) &&
                  (curMode == MODE_NORMAL) && !modeChange;
  end

  // mode history and settling timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePrev         <= MODE_STANDBY;
      listenFromNormal <= 1'b0;
      settleCnt        <= '0;
      pwonPrev         <= 1'b0;
    end else begin
      modePrev <= curMode;
      pwonPrev <= pwonFlag;
      if (modeChange && curMode == MODE_LISTEN)
        listenFromNormal <= (modePrev == MODE_NORMAL);
      if (modeChange)
        settleCnt <= SET_LOAD;
      else if (settleCnt != '0)
        settleCnt <= settleCnt - 1'b1;
    end
  end

  // dominant-phase length and qualified edge counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txdPrev <= 1'b1;
      domCnt  <= '0;
      edgeCnt <= '0;
    end else begin
      txdPrev <= txd;
      if (txd)
        domCnt <= '0;
      else if (domCnt < DOM_MAX)
        domCnt <= domCnt + 1'b1;
      if (enterNormal)
        edgeCnt <= '0;
      else if (qualEdge && edgeCnt < EDGE_MAX)
        edgeCnt <= edgeCnt + 1'b1;
    end
  end

  // strobes to the datapath
  always_comb begin
    ctl.clrWake   = leaveNormal;
    ctl.clrBus    = enterNormal || pwonRise;
    ctl.clrLocal  = enterNormal || pwonRise ||
                    (!rxd && txd && !localFailActive);
    ctl.updateOut = !modeChange && (settleCnt == '0);
    case (curMode)
      MODE_NORMAL: ctl.sel = (edgeCnt >= EDGE_MAX) ? SHOW_BUS : SHOW_WAKE;
      MODE_LISTEN: ctl.sel = listenFromNormal ? SHOW_LOCAL : SHOW_PWON;
      default:     ctl.sel = SHOW_HIGH;
    endcase
  end

  // R3
  edge_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= EDGE_MAX);

  // R5
  edge_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    enterNormal |=> (edgeCnt == '0));

  // R11
  settle_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |=> (settleCnt == SET_LOAD));

endmodule

// File: rtl/diag_flag_datapath.sv
module diag_flag_datapath
  import diag_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  logic        setWakeSrc,
  input  logic        setBusFail,
  input  logic        setLocalFail,
  input  logic        pwonFlag,
  output logic        errN
);

  logic wakeSrc, busFail, localFail;
  logic shownLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeSrc   <= 1'b0;
      busFail   <= 1'b0;
      localFail <= 1'b0;
    end else begin
      if (ctl.clrWake)       wakeSrc   <= 1'b0;
      else if (setWakeSrc)   wakeSrc   <= 1'b1;
      if (ctl.clrBus)        busFail   <= 1'b0;
      else if (setBusFail)   busFail   <= 1'b1;
      if (ctl.clrLocal)      localFail <= 1'b0;
      else if (setLocalFail) localFail <= 1'b1;
    end
  end

  always_comb begin
    case (ctl.sel)
      SHOW_WAKE:  shownLevel = ~wakeSrc;
      SHOW_BUS:   shownLevel = ~busFail;
      SHOW_LOCAL: shownLevel = ~localFail;
      SHOW_PWON:  shownLevel = ~pwonFlag;
      default:    shownLevel = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errN <= 1'b1;
    else if (ctl.updateOut) errN <= shownLevel;
  end

  // R7
  quiet_mode_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.updateOut && ctl.sel == SHOW_HIGH) |=> errN);

  // R8
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrWake |=> !wakeSrc);

  // R9
  bus_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrBus |=> !busFail);

  // R10
  local_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrLocal |=> !localFail);

  // R11
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.updateOut |=> $stable(errN));

endmodule

// File: rtl/diag_flag_mux.sv
module diag_flag_mux
  import diag_flag_pkg::*;
#(
  parameter int MIN_DOM_CYC = 800,
  parameter int SETTLE_CYC  = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       txd,
  input  logic       rxd,
  input  logic       setWakeSrc,
  input  logic       setBusFail,
  input  logic       setLocalFail,
  input  logic       localFailActive,
  input  logic       pwonFlag,
  output logic       errN
);

  ctlStrobes_t ctl;

  diag_flag_ctrl #(
    .MIN_DOM_CYC(MIN_DOM_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .EDGE_LIMIT (4)
  ) uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .mode           (mode),
    .txd            (txd),
    .rxd            (rxd),
    .localFailActive(localFailActive),
    .pwonFlag       (pwonFlag),
    .ctl            (ctl)
  );

  diag_flag_datapath uData (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .setWakeSrc  (setWakeSrc),
    .setBusFail  (setBusFail),
    .setLocalFail(setLocalFail),
    .pwonFlag    (pwonFlag),
    .errN        (errN)
  );

endmodule

// File: tb/diag_flag_mux_test.sv
module diag_flag_mux_test;

  localparam int MIN = 4;
  localparam int SET = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'd2;
  logic txd = 1'b1, rxd = 1'b1;
  logic setWakeSrc = 1'b0, setBusFail = 1'b0, setLocalFail = 1'b0;
  logic localFailActive = 1'b0, pwonFlag = 1'b0;
  logic errN;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  diag_flag_mux #(.MIN_DOM_CYC(MIN), .SETTLE_CYC(SET)) uut (
    .clk(clk), .rstN(rstN), .mode(mode), .txd(txd), .rxd(rxd),
    .setWakeSrc(setWakeSrc), .setBusFail(setBusFail),
    .setLocalFail(setLocalFail), .localFailActive(localFailActive),
    .pwonFlag(pwonFlag), .errN(errN)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic expv);
    testsRun++;
    if (errN !== expv) begin
      testsFailed++;
      $display("FAIL %s: errN=%b expected %b", req, errN, expv);
    end
  endtask

  task automatic setMode(input logic [1:0] m);
    mode = m;
    tick(SET + 3);
  endtask

  task automatic dominant(input int len);
    txd = 1'b0;
    tick(len);
    txd = 1'b1;
    tick(1);
  endtask

  task automatic pulseSet(input int which);
    case (which)
      0: setWakeSrc = 1'b1;
      1: setBusFail = 1'b1;
      default: setLocalFail = 1'b1;
    endcase
    tick(1);
    setWakeSrc = 1'b0; setBusFail = 1'b0; setLocalFail = 1'b0;
    tick(2);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    check("R1", 1'b1);

    // R7: flags set in Standby and Sleep leave the pin high
    pulseSet(0); pulseSet(1); pulseSet(2);
    check("R7", 1'b1);
    setMode(2'd3);
    check("R7", 1'b1);

    // R11: hold across the window, then show wake-up source (R2)
    mode = 2'd0;
    for (int i = 0; i < SET + 1; i++) begin
      tick(1);
      check("R11", 1'b1);
    end
    tick(1);
    check("R2", 1'b0);

    // R4: short dominant phases do not count
    for (int k = 0; k < 5; k++) dominant(MIN - 1);
    tick(2);
    check("R4", 1'b0);

    // R3: qualified edges; bus flag was cleared on Normal entry
    for (int n = 1; n <= 5; n++) begin
      dominant(MIN);
      tick(2);
      check("R3", (n >= 4) ? 1'b1 : 1'b0);
    end
    pulseSet(1);
    check("R12", 1'b0);

    // R9: power-on rise clears bus failure
    pwonFlag = 1'b1;
    tick(2);
    check("R9", 1'b1);
    pwonFlag = 1'b0;
    tick(2);

    // R4 and R5 sweep of first pulse length around the threshold
    for (int len = 1; len <= MIN + 2; len++) begin
      setMode(2'd2);
      setMode(2'd0);
      pulseSet(0);
      dominant(len);
      for (int k = 0; k < 3; k++) dominant(MIN);
      tick(2);
      check((len >= MIN) ? "R3" : "R4", (len >= MIN) ? 1'b1 : 1'b0);
    end
    // R5: re-entry restarts the count, wake flag shown again
    setMode(2'd2);
    setMode(2'd0);
    pulseSet(0);
    check("R5", 1'b0);

    // R6 / R8: Listen from Normal shows local failure
    setMode(2'd1);
    check("R6", 1'b1);
    pulseSet(2);
    check("R6", 1'b0);
    setMode(2'd0);
    check("R8", 1'b1);
    setMode(2'd1);
    check("R10", 1'b1);

    // R10: RXD/TXD clear blocked while failure active
    pulseSet(2);
    check("R12", 1'b0);
    localFailActive = 1'b1;
    rxd = 1'b0;
    tick(3);
    check("R10", 1'b0);
    localFailActive = 1'b0;
    tick(2);
    check("R10", 1'b1);
    rxd = 1'b1;

    // R10: power-on rise clears local failure
    pulseSet(2);
    check("R10", 1'b0);
    pwonFlag = 1'b1;
    tick(2);
    check("R10", 1'b1);
    pwonFlag = 1'b0;
    tick(2);

    // R6: Listen from Standby shows power-on level
    setMode(2'd2);
    setMode(2'd1);
    check("R6", 1'b1);
    pwonFlag = 1'b1;
    tick(2);
    check("R6", 1'b0);
    pwonFlag = 1'b0;
    tick(2);
    check("R6", 1'b1);

    // R12: clear wins over a simultaneous set (Normal entry with set bus)
    setMode(2'd2);
    mode = 2'd0;
    setBusFail = 1'b1;
    tick(1);
    setBusFail = 1'b0;
    tick(SET + 3);
    for (int k = 0; k < 4; k++) dominant(MIN);
    tick(2);
    check("R12", 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule